// File: doc/BRIEF.md
# Paper Tape Binary Loader

This block turns a stream of eight-bit paper tape frames into memory writes. One frame arrives with each cycle in which the strobe is high. The two top bits of a frame give its kind. Runout frames (leader and trailer) frame a segment. Origin and data frames come in pairs that together carry a twelve-bit word. A single field frame selects the three-bit memory field used by the writes that follow it.

Within a segment, an origin word sets the load address. Each data word is written to that address, and the address then steps by one. The loader keeps a running twelve-bit sum of every origin and data byte. The last word before the trailer is the tape's own checksum. Because that word cannot be told apart from data until the next frame arrives, the loader holds back the newest data word by one frame. When a trailer arrives, the held word is compared with the sum instead of being written. The result is reported with a one-cycle pulse.

A tape can hold any number of segments, each with its own checksum. The load address and the field carry over from one segment to the next. Reset returns the loader to waiting for leader.

Top module: `tape_bin_loader`

## Requirements
- R1: After a synchronous active-high reset, the loader drives no write and no segment pulse. It ignores every frame until the first runout frame (top bits 10). Reset also clears the address, the field and the sum to zero.
- R2: A word is assembled from two frames. Bits 5:0 of the first frame form word bits 11:6, and bits 5:0 of the second frame form word bits 5:0. The second frame is taken whatever its top bits are.
- R3: A word whose first frame has top bits 01 sets the load address. Each data word (first frame top bits 00) is written to the current address, and the address then increments by one, wrapping from 0xFFF to 0x000.
- R4: A run of runout frames of any length, including a run of one, is accepted as leader or trailer. A segment that holds no data word produces no segment pulse.
- R5: A frame with top bits 11, arriving between words or inside a runout run, is a single-frame field command. Its bits 5:3 become the field for all later writes, and it adds nothing to the sum.
- R6: The sum is the twelve-bit modulo sum of the byte values of all origin and data frames in the segment. The last word before the trailer is excluded from the sum and is never written.
- R7: When a trailer frame follows a held data word, segment_done is high for exactly one cycle, on the cycle after that frame's strobe. checksum_ok is high in that cycle only if the held word equals the sum.
- R8: A new leader and segment may follow a trailer directly. The sum restarts at zero for each segment.
- R9: A data write appears on the cycle after the strobe of the frame that follows the data word, and no write or segment pulse follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | Strobe: frame_data holds a tape frame this cycle |
| frame_data | input | 8 | Tape frame; bits 7:6 give its kind |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_field | output | 3 | Memory field of the write |
| wr_addr | output | 12 | Address of the write |
| wr_data | output | 12 | Word to write |
| segment_done | output | 1 | One-cycle pulse when a segment's checksum has been compared |
| checksum_ok | output | 1 | Valid with segment_done: the tape checksum matched |

## Verification
The assertions take for granted that frames come only through the strobe, with one frame per strobe. They also assume a data segment ends with a trailer frame at a word boundary, never in the middle of a word pair. The stimulus builds whole tapes from origin, data, field and checksum words, so every pair is complete before a trailer or field frame. It inserts strobe-free gaps that carry junk bytes on frame_data, to show these bytes are ignored. Tape bytes placed before the first leader, including a field command, test that idle input is ignored.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
   typedef enum logic [1:0] {
      FT_DATA   = 2'd0,
      FT_ORIGIN = 2'd1,
      FT_RUNOUT = 2'd2,
      FT_FIELD  = 2'd3
   } ftype_t;

   typedef enum logic [1:0] {
      PS_IDLE,
      PS_RUNOUT,
      PS_HIGH,
      PS_LOW
   } pstate_t;
endpackage

// File: rtl/tbl_framer.sv
module tbl_framer
   import tbl_pkg::*;
#(
   parameter int HALF_W  = 6,
   parameter int FIELD_W = 3,
   localparam int FRAME_W = HALF_W + 2,
   localparam int WORD_W  = 2 * HALF_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               strobe,
   input  logic [FRAME_W-1:0] frame,
   output logic               ev_open,
   output logic               ev_word,
   output logic [WORD_W-1:0]  word,
   output logic               word_org,
   output logic [FRAME_W-1:0] word_hi,
   output logic [FRAME_W-1:0] word_lo,
   output logic               ev_field,
   output logic [FIELD_W-1:0] field_val,
   output logic               ev_trail
);
   initial assert (FIELD_W <= HALF_W) else $error("field does not fit in a half word");

   pstate_t            state_q, state_d;
   logic [FRAME_W-1:0] hi_q;
   ftype_t             kind;
   logic               between;

   always_comb begin
      kind      = ftype_t'(frame[FRAME_W-1 -: 2]);
      between   = (state_q == PS_RUNOUT) || (state_q == PS_HIGH);
      ev_open   = strobe && between && ((kind == FT_DATA) || (kind == FT_ORIGIN));
      ev_field  = strobe && between && (kind == FT_FIELD);
      ev_trail  = strobe && (state_q == PS_HIGH) && (kind == FT_RUNOUT);
      ev_word   = strobe && (state_q == PS_LOW);
      word      = {hi_q[HALF_W-1:0], frame[HALF_W-1:0]};
      word_org  = hi_q[HALF_W];
      word_hi   = hi_q;
      word_lo   = frame;
      field_val = frame[HALF_W-1 -: FIELD_W];
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         PS_IDLE:   if (strobe && kind == FT_RUNOUT) state_d = PS_RUNOUT;
         PS_RUNOUT: if (ev_open) state_d = PS_LOW;
         PS_HIGH: begin
            if (ev_open)       state_d = PS_LOW;
            else if (ev_trail) state_d = PS_RUNOUT;
         end
         PS_LOW:    if (strobe) state_d = PS_HIGH;
         default:   state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_IDLE;
         hi_q    <= '0;
      end else begin
         state_q <= state_d;
         if (ev_open) hi_q <= frame;
      end
   end

   // R1: nothing before the first leader produces a word or a trailer
   a_r1_idle_silent: assert property (@(posedge clk) disable iff (rst)
      (state_q == PS_IDLE) |-> (!ev_word && !ev_trail && !ev_field));
   // R2: a second frame always closes the pair
   a_r2_pair_closes: assert property (@(posedge clk) disable iff (rst)
      ev_word |=> (state_q == PS_HIGH));
endmodule

// File: rtl/tbl_store.sv
module tbl_store #(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3,
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ev_open,
   input  logic               ev_word,
   input  logic [WORD_W-1:0]  word,
   input  logic               word_org,
   input  logic [FRAME_W-1:0] word_hi,
   input  logic [FRAME_W-1:0] word_lo,
   input  logic               ev_field,
   input  logic [FIELD_W-1:0] field_val,
   input  logic               ev_trail,
   output logic               wr_en,
   output logic [FIELD_W-1:0] wr_field,
   output logic [WORD_W-1:0]  wr_addr,
   output logic [WORD_W-1:0]  wr_data,
   output logic               sum_en,
   output logic [FRAME_W-1:0] sum_hi,
   output logic [FRAME_W-1:0] sum_lo,
   output logic               pend_valid,
   output logic [WORD_W-1:0]  pend_word
);
   logic [WORD_W-1:0]  addr_q;
   logic [FIELD_W-1:0] field_q;
   logic               pend_q;
   logic [WORD_W-1:0]  pword_q;
   logic [FRAME_W-1:0] phi_q, plo_q;
   logic               commit, set_org;

   always_comb begin
      commit     = (ev_open || ev_field) && pend_q;
      set_org    = ev_word && word_org;
      sum_en     = commit || set_org;
      sum_hi     = set_org ? word_hi : phi_q;
      sum_lo     = set_org ? word_lo : plo_q;
      pend_valid = pend_q;
      pend_word  = pword_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q   <= '0;
         field_q  <= '0;
         pend_q   <= 1'b0;
         pword_q  <= '0;
         phi_q    <= '0;
         plo_q    <= '0;
         wr_en    <= 1'b0;
         wr_field <= '0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= commit;
         if (commit) begin
            wr_field <= field_q;
            wr_addr  <= addr_q;
            wr_data  <= pword_q;
            addr_q   <= addr_q + WORD_W'(1);
            pend_q   <= 1'b0;
         end
         if (ev_field) field_q <= field_val;
         if (ev_trail) pend_q <= 1'b0;
         if (set_org) addr_q <= word;
         if (ev_word && !word_org) begin
            pend_q  <= 1'b1;
            pword_q <= word;
            phi_q   <= word_hi;
            plo_q   <= word_lo;
         end
      end
   end

   // R6: the word held at a trailer is never written
   a_r6_no_write_on_trailer: assert property (@(posedge clk) disable iff (rst)
      ev_trail |=> !wr_en);
   // R3: every write advances the load address by one
   a_r3_addr_advance: assert property (@(posedge clk) disable iff (rst)
      commit |=> (addr_q == $past(addr_q) + WORD_W'(1)));
   // R5: a field command alone contributes nothing to the sum
   a_r5_field_no_sum: assert property (@(posedge clk) disable iff (rst)
      (ev_field && !pend_q) |-> !sum_en);
endmodule

// File: rtl/tbl_sum.sv
module tbl_sum #(
   parameter int WORD_W   = 12,
   parameter int HALF_W   = 6,
   parameter int FRAME_W  = 8,
   parameter bit PER_BYTE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               add_en,
   input  logic [FRAME_W-1:0] add_hi,
   input  logic [FRAME_W-1:0] add_lo,
   input  logic               close,
   input  logic               close_chk,
   input  logic [WORD_W-1:0]  chk_val,
   output logic               seg_done,
   output logic               seg_ok
);
   initial assert (WORD_W > FRAME_W) else $error("frame wider than the sum");

   logic [WORD_W-1:0] sum_q, addend;

   generate
      if (PER_BYTE) begin : g_bytes
         always_comb addend = {{(WORD_W-FRAME_W){1'b0}}, add_hi}
                            + {{(WORD_W-FRAME_W){1'b0}}, add_lo};
      end else begin : g_words
         always_comb addend = {add_hi[HALF_W-1:0], add_lo[HALF_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q    <= '0;
         seg_done <= 1'b0;
         seg_ok   <= 1'b0;
      end else begin
         seg_done <= close && close_chk;
         seg_ok   <= close && close_chk && (sum_q == chk_val);
         if (close)       sum_q <= '0;
         else if (add_en) sum_q <= sum_q + addend;
      end
   end

   // R7: the segment result is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
      seg_done |=> !seg_done);
   // R7: a pass is only reported together with the pulse
   a_r7_ok_with_done: assert property (@(posedge clk) disable iff (rst)
      seg_ok |-> seg_done);
   // R8: the sum starts from zero after every trailer
   a_r8_sum_restart: assert property (@(posedge clk) disable iff (rst)
      close |=> (sum_q == '0));
endmodule

// File: rtl/tape_bin_loader.sv
module tape_bin_loader #(
   parameter int WORD_W       = 12,
   parameter int FIELD_W      = 3,
   parameter bit SUM_PER_BYTE = 1'b1,
   localparam int HALF_W  = WORD_W / 2,
   localparam int FRAME_W = HALF_W + 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               frame_valid,
   input  logic [FRAME_W-1:0] frame_data,
   output logic               wr_en,
   output logic [FIELD_W-1:0] wr_field,
   output logic [WORD_W-1:0]  wr_addr,
   output logic [WORD_W-1:0]  wr_data,
   output logic               segment_done,
   output logic               checksum_ok
);
   initial assert (WORD_W % 2 == 0 && HALF_W >= 3) else $error("word width must be even and at least 6");

   logic               ev_open, ev_word, word_org, ev_field, ev_trail;
   logic [WORD_W-1:0]  word;
   logic [FRAME_W-1:0] word_hi, word_lo;
   logic [FIELD_W-1:0] field_val;
   logic               sum_en, pend_valid;
   logic [FRAME_W-1:0] sum_hi, sum_lo;
   logic [WORD_W-1:0]  pend_word;

   tbl_framer #(.HALF_W(HALF_W), .FIELD_W(FIELD_W)) i_framer (
      .clk(clk), .rst(rst), .strobe(frame_valid), .frame(frame_data),
      .ev_open(ev_open), .ev_word(ev_word), .word(word), .word_org(word_org),
      .word_hi(word_hi), .word_lo(word_lo), .ev_field(ev_field),
      .field_val(field_val), .ev_trail(ev_trail)
   );

   tbl_store #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .FRAME_W(FRAME_W)) i_store (
      .clk(clk), .rst(rst), .ev_open(ev_open), .ev_word(ev_word), .word(word),
      .word_org(word_org), .word_hi(word_hi), .word_lo(word_lo),
      .ev_field(ev_field), .field_val(field_val), .ev_trail(ev_trail),
      .wr_en(wr_en), .wr_field(wr_field), .wr_addr(wr_addr), .wr_data(wr_data),
      .sum_en(sum_en), .sum_hi(sum_hi), .sum_lo(sum_lo),
      .pend_valid(pend_valid), .pend_word(pend_word)
   );

   tbl_sum #(.WORD_W(WORD_W), .HALF_W(HALF_W), .FRAME_W(FRAME_W),
             .PER_BYTE(SUM_PER_BYTE)) i_sum (
      .clk(clk), .rst(rst), .add_en(sum_en), .add_hi(sum_hi), .add_lo(sum_lo),
      .close(ev_trail), .close_chk(pend_valid), .chk_val(pend_word),
      .seg_done(segment_done), .seg_ok(checksum_ok)
   );

   // R9: a cycle without a strobe is followed by no write and no result
   a_r9_quiet_without_strobe: assert property (@(posedge clk) disable iff (rst)
      !frame_valid |=> (!wr_en && !segment_done));
endmodule

// File: tb/test_tape_bin_loader.sv
module test_tape_bin_loader;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        frame_valid = 1'b0;
   logic [7:0]  frame_data = 8'h00;
   logic        wr_en, segment_done, checksum_ok;
   logic [2:0]  wr_field;
   logic [11:0] wr_addr, wr_data;

   always #4 clk = ~clk;

   tape_bin_loader i_tape_bin_loader (
      .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
      .wr_en(wr_en), .wr_field(wr_field), .wr_addr(wr_addr), .wr_data(wr_data),
      .segment_done(segment_done), .checksum_ok(checksum_ok)
   );

   int vectors = 0, miscompares = 0;
   logic [7:0]  tape [0:1023];
   int          tlen = 0;
   logic [26:0] exp_w [0:255];
   int          ew_n = 0, ew_rd = 0;
   logic        exp_ok [0:7];
   int          ed_n = 0, ed_rd = 0;
   logic [11:0] b_addr = '0, seg_sum = '0;
   logic [2:0]  b_field = '0;
   int          stray = 0;
   logic        v_edge = 1'b0;
   bit          done_flag = 0;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   task automatic put_byte(input logic [7:0] b);
      tape[tlen] = b;
      tlen++;
   endtask

   task automatic put_runout(input int n);
      for (int i = 0; i < n; i++) put_byte(8'h80);
   endtask

   task automatic put_pair(input logic [1:0] kind, input logic [11:0] w, input bit summed);
      logic [7:0] hi, lo;
      hi = {kind, w[11:6]};
      lo = {2'b00, w[5:0]};
      put_byte(hi);
      put_byte(lo);
      if (summed) seg_sum = seg_sum + 12'(hi) + 12'(lo);
   endtask

   task automatic put_origin(input logic [11:0] a);
      put_pair(2'b01, a, 1'b1);
      b_addr = a;
   endtask

   task automatic put_data(input logic [11:0] d);
      put_pair(2'b00, d, 1'b1);
      exp_w[ew_n] = {b_field, b_addr, d};
      ew_n++;
      b_addr = b_addr + 12'd1;
   endtask

   task automatic put_field(input logic [2:0] f);
      put_byte({2'b11, f, 3'b000});
      b_field = f;
   endtask

   task automatic put_check(input logic [11:0] flip);
      put_pair(2'b00, seg_sum ^ flip, 1'b0);
      exp_ok[ed_n] = (flip == 12'd0);
      ed_n++;
      seg_sum = '0;
   endtask

   // strobe-free gaps carry junk on frame_data (R9)
   task automatic feed(input int from, input int to);
      for (int i = from; i < to; i++) begin
         if (i % 7 == 3) begin
            repeat (2) begin
               @(negedge clk);
               frame_valid = 1'b0;
               frame_data  = 8'h5A;
            end
         end
         @(negedge clk);
         frame_valid = 1'b1;
         frame_data  = tape[i];
      end
      @(negedge clk);
      frame_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   always @(posedge clk) v_edge <= frame_valid;

   always @(negedge clk) begin
      if (!rst) begin
         if (wr_en && !v_edge) stray++;
         if (segment_done && !v_edge) stray++;
         if (wr_en) begin
            if (ew_rd < ew_n)
               check({wr_field, wr_addr, wr_data} == exp_w[ew_rd],
                     "R2/R3/R5 write field,addr,data", int'({wr_field, wr_addr, wr_data}),
                     int'(exp_w[ew_rd]));
            else
               check(1'b0, "R6 unexpected write", int'({wr_field, wr_addr, wr_data}), 0);
            ew_rd++;
         end
         if (segment_done) begin
            if (ed_rd < ed_n)
               check(checksum_ok == exp_ok[ed_rd], "R6/R7/R8 segment checksum result",
                     int'(checksum_ok), int'(exp_ok[ed_rd]));
            else
               check(1'b0, "R4/R7 unexpected segment pulse", 1, 0);
            ed_rd++;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      int mark;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!wr_en && !segment_done && !checksum_ok, "R1 reset outputs quiet",
            int'({wr_en, segment_done, checksum_ok}), 0);

      // junk before leader, including a field command: ignored (R1)
      put_byte(8'h41); put_byte(8'hC8); put_byte(8'h07); put_byte(8'h3F);
      put_runout(16);
      put_origin(12'h080);
      for (int i = 0; i < 20; i++) put_data(12'((i * 301 + 7) & 12'hFFF));
      put_field(3'd3);
      put_origin(12'hFFE);
      for (int i = 0; i < 4; i++) put_data(12'((i * 1111 + 42) & 12'hFFF));
      put_check(12'd0);
      put_runout(16);
      // second segment directly after the trailer, field set inside the leader (R8)
      put_runout(1);
      put_field(3'd5);
      put_runout(3);
      put_origin(12'h100);
      for (int i = 0; i < 64; i++) put_data(12'(i * 65));
      put_check(12'd0);
      put_runout(1);
      mark = tlen;
      put_runout(10);
      feed(0, tlen);
      check(ed_rd == 2, "R4 pulses after leader-only run", ed_rd, 2);
      check(ew_rd == ew_n, "R3 writes of first tape", ew_rd, ew_n);
      check(mark > 0, "R4 runout run length", mark, 1);

      // reset, then a tape with a wrong checksum; field returns to 0 (R1)
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      b_field = '0;
      mark = tlen;
      put_runout(5);
      put_origin(12'h010);
      for (int i = 0; i < 6; i++) put_data(12'(12'hFC0 + i));
      put_check(12'h001);
      put_runout(2);
      feed(mark, tlen);

      check(ew_rd == ew_n, "R3/R6 total write count", ew_rd, ew_n);
      check(ed_rd == ed_n, "R7 total segment pulses", ed_rd, ed_n);
      check(stray == 0, "R9 outputs after strobe-free cycles", stray, 0);
      report();
   end
endmodule